// File: doc/BRIEF.md
# Hierarchical Interrupt Controller

This block gathers interrupt events from up to eight peripheral modules, each with up to eight sources, and turns them into one request line toward a CPU. Each source keeps a sticky flag, set by a one-cycle event pulse, and has its own enable bit. The request passes three gates in series: the source enable, the enable of the module that owns the source, and one global enable. Every interrupt uses the same programmable vector address. That address is 0000h until software writes the vector register.

Software reaches the flags, the enables and the vector through a small register port. Writes take effect at the clock edge. Reads are combinational. An identification register shows which modules hold a pending enabled source. It also shows whether that pending work belongs to a system module or a peripheral module.

A flag is cleared by writing a one to its bit. After such a clear, the request is held low for a settling window. The window is one cycle when only asynchronous sources were cleared and two cycles when a synchronous source was among them. This stops a stale flag from causing a second entry. An acknowledge input masks the request until a return input arrives, so the service routine cannot be re-entered.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset every flag, source enable, module enable, the global enable and the vector register read 0, and `irq_o` is 0.
- R2: A one-cycle pulse on `evt_i[m*SRC_N+s]` sets flag bit s of module m, read at address m (0..7). The flag stays set until a write to that address with bit s at 1 clears it.
- R3: When an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R4: `irq_o` is 1 only when some source has its flag and its enable set (enable register at address 8+m, bit s), the bit m of the module-enable register at address 16 is set, and bit 0 of the global register at address 17 is set.
- R5: `irq_vec_o` always shows the vector register (address 18). It is 0000h until written and changes only on a write to address 18.
- R6: The identification register at address 19 holds, in bit m, whether module m has a flagged and enabled source and its module enable set, regardless of the global enable. Bit NUM_MOD is set when any such module is a system module (its bit in SYS_MODS is 1). Bit NUM_MOD+1 is set when any such module is a peripheral module.
- R7: After a write that clears at least one flag bit, `irq_o` stays 0 for one cycle when every cleared bit is asynchronous. It stays 0 for two cycles when any cleared bit is synchronous, meaning its bit in SYNC_SRCS is 1.
- R8: An `ack_i` pulse forces `irq_o` to 0 from the next cycle until the cycle after a `ret_i` pulse. If `ack_i` and `ret_i` arrive together, the mask stays on.
- R9: Registers read back what was written, within their widths. Unmapped addresses read 0. Writes to address 19 or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_MOD*SRC_N | One-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | DATA_W | Combinational read data |
| ack_i | input | 1 | CPU has taken the interrupt |
| ret_i | input | 1 | CPU has returned from the service routine |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | DATA_W | Service routine address |

## Verification
The bench builds the block with its defaults: eight modules of eight sources, modules 0 and 1 marked as system, and every odd-numbered source marked as synchronous. This makes both identification class bits and both settling window lengths reachable. Directed sequences on module 2 and module 0 cover the settling windows, the set-over-clear case and each gate level. A random phase then mixes sparse events, writes anywhere in the map, and acknowledge/return pulses, with a model of all state in the bench checking every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W    = 5;
  localparam int FLAG_BASE = 0;
  localparam int EN_BASE   = 8;
  localparam logic [ADDR_W-1:0] A_MODEN = 5'd16;
  localparam logic [ADDR_W-1:0] A_GLOB  = 5'd17;
  localparam logic [ADDR_W-1:0] A_VEC   = 5'd18;
  localparam logic [ADDR_W-1:0] A_IDENT = 5'd19;

  // Length of the quiet window that follows a flag clear
  function automatic logic [1:0] settle_len(input logic any_clr, input logic any_sync);
    if (any_sync) return 2'd2;
    if (any_clr)  return 2'd1;
    return 2'd0;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int SRC_N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] evt_i,
  input  logic [SRC_N-1:0] clr_i,
  input  logic             en_we_i,
  input  logic [SRC_N-1:0] en_wdata_i,
  output logic [SRC_N-1:0] flag_o,
  output logic [SRC_N-1:0] en_o,
  output logic             pend_o
);
  logic [SRC_N-1:0] flag_q, en_q;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_i) | evt_i;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign pend_o = |(flag_q & en_q);
endmodule

// File: rtl/irq_settle.sv
module irq_settle import irq_pkg::*; #(
  parameter int TOT = 64,
  parameter logic [TOT-1:0] SYNC_SRCS = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [TOT-1:0] clr_i,
  output logic           busy_o
);
  logic [1:0] cnt_q, load;

  assign load = settle_len(|clr_i, |(clr_i & SYNC_SRCS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= 2'd0;
    else if (load != 2'd0) cnt_q <= load;
    else if (cnt_q != 2'd0) cnt_q <= cnt_q - 2'd1;
  end

  assign busy_o = (cnt_q != 2'd0);
endmodule

// File: rtl/irq_ident.sv
module irq_ident #(
  parameter int NUM_MOD = 8,
  parameter int DATA_W  = 16,
  parameter logic [NUM_MOD-1:0] SYS_MODS = '0
) (
  input  logic [NUM_MOD-1:0] pend_i,
  input  logic [NUM_MOD-1:0] mod_en_i,
  output logic [NUM_MOD-1:0] live_o,
  output logic [DATA_W-1:0]  ident_o
);
  // class bits: {peripheral, system}
  function automatic logic [1:0] pend_class(input logic [NUM_MOD-1:0] live);
    return {|(live & ~SYS_MODS), |(live & SYS_MODS)};
  endfunction

  assign live_o = pend_i & mod_en_i;

  always_comb begin
    ident_o = '0;
    ident_o[NUM_MOD-1:0]         = live_o;
    ident_o[NUM_MOD+1:NUM_MOD]   = pend_class(live_o);
  end
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl import irq_pkg::*; #(
  parameter int NUM_MOD = 8,
  parameter int SRC_N   = 8,
  parameter int DATA_W  = 16,
  parameter logic [NUM_MOD-1:0] SYS_MODS = 8'h03,
  parameter logic [NUM_MOD*SRC_N-1:0] SYNC_SRCS = {(NUM_MOD*SRC_N/2){2'b10}}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_MOD*SRC_N-1:0] evt_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic                     ack_i,
  input  logic                     ret_i,
  output logic                     irq_o,
  output logic [DATA_W-1:0]        irq_vec_o
);
  localparam int TOT = NUM_MOD * SRC_N;

  logic [NUM_MOD-1:0][SRC_N-1:0] flags, ens;
  logic [TOT-1:0]     clr_flat, flags_flat;
  logic [NUM_MOD-1:0] pend_src, mod_live, mod_en_q;
  logic               glob_q, in_svc_q, settle_busy, vec_we;
  logic [DATA_W-1:0]  vec_q, ident;

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    localparam logic [ADDR_W-1:0] A_F = ADDR_W'(FLAG_BASE + m);
    localparam logic [ADDR_W-1:0] A_E = ADDR_W'(EN_BASE + m);
    assign clr_flat[m*SRC_N +: SRC_N] =
      (wr_en_i && wr_addr_i == A_F) ? wr_data_i[SRC_N-1:0] : '0;
    irq_src_bank #(.SRC_N(SRC_N)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[m*SRC_N +: SRC_N]),
      .clr_i      (clr_flat[m*SRC_N +: SRC_N]),
      .en_we_i    (wr_en_i && wr_addr_i == A_E),
      .en_wdata_i (wr_data_i[SRC_N-1:0]),
      .flag_o     (flags[m]),
      .en_o       (ens[m]),
      .pend_o     (pend_src[m])
    );
    assign flags_flat[m*SRC_N +: SRC_N] = flags[m];
  end

  irq_settle #(.TOT(TOT), .SYNC_SRCS(SYNC_SRCS)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_flat),
    .busy_o (settle_busy)
  );

  irq_ident #(.NUM_MOD(NUM_MOD), .DATA_W(DATA_W), .SYS_MODS(SYS_MODS)) u_ident (
    .pend_i   (pend_src),
    .mod_en_i (mod_en_q),
    .live_o   (mod_live),
    .ident_o  (ident)
  );

  assign vec_we = wr_en_i && (wr_addr_i == A_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_en_q <= '0;
      glob_q   <= 1'b0;
      vec_q    <= '0;
      in_svc_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_MODEN) mod_en_q <= wr_data_i[NUM_MOD-1:0];
      if (wr_en_i && wr_addr_i == A_GLOB)  glob_q   <= wr_data_i[0];
      if (vec_we)                          vec_q    <= wr_data_i;
      if (ack_i)      in_svc_q <= 1'b1;
      else if (ret_i) in_svc_q <= 1'b0;
    end
  end

  assign irq_o     = (|mod_live) & glob_q & ~in_svc_q & ~settle_busy;
  assign irq_vec_o = vec_q;

  always_comb begin
    rd_data_o = '0;
    for (int m = 0; m < NUM_MOD; m++) begin
      if (rd_addr_i == ADDR_W'(FLAG_BASE + m)) rd_data_o[SRC_N-1:0] = flags[m];
      if (rd_addr_i == ADDR_W'(EN_BASE + m))   rd_data_o[SRC_N-1:0] = ens[m];
    end
    if (rd_addr_i == A_MODEN) rd_data_o[NUM_MOD-1:0] = mod_en_q;
    if (rd_addr_i == A_GLOB)  rd_data_o[0] = glob_q;
    if (rd_addr_i == A_VEC)   rd_data_o = vec_q;
    if (rd_addr_i == A_IDENT) rd_data_o = ident;
  end
endmodule

// File: rtl/irq_hier_chk.sv
module irq_hier_chk #(
  parameter int NUM_MOD = 8,
  parameter int TOT     = 64,
  parameter int DATA_W  = 16,
  parameter logic [TOT-1:0] SYNC_SRCS = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [TOT-1:0]     evt_i,
  input logic [TOT-1:0]     clr_i,
  input logic [TOT-1:0]     flags_i,
  input logic               glob_i,
  input logic [NUM_MOD-1:0] mod_en_i,
  input logic               ack_i,
  input logic               irq_i,
  input logic               vec_we_i,
  input logic [DATA_W-1:0]  vec_i,
  input logic [NUM_MOD+1:0] ident_i
);
  assert_flag_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flags_i) & ~flags_i & ~$past(clr_i)) == '0));

  assert_set_beats_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & clr_i) != '0) |=> ((flags_i & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));

  assert_three_gates_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (glob_i && (mod_en_i != '0) && (flags_i != '0)));

  assert_vector_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vec_we_i) |-> $stable(vec_i));

  assert_class_cover_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ident_i[NUM_MOD] | ident_i[NUM_MOD+1]) == (|ident_i[NUM_MOD-1:0])));

  assert_settle_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> !irq_i);

  assert_settle_second_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & SYNC_SRCS) != '0) |-> ##2 !irq_i);

  assert_ack_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_i);
endmodule

bind irq_hier_ctrl irq_hier_chk #(
  .NUM_MOD(NUM_MOD), .TOT(TOT), .DATA_W(DATA_W), .SYNC_SRCS(SYNC_SRCS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .clr_i    (clr_flat),
  .flags_i  (flags_flat),
  .glob_i   (glob_q),
  .mod_en_i (mod_en_q),
  .ack_i    (ack_i),
  .irq_i    (irq_o),
  .vec_we_i (vec_we),
  .vec_i    (irq_vec_o),
  .ident_i  (ident[NUM_MOD+1:0])
);

// File: tb/sim_irq_hier_ctrl.sv
module sim_irq_hier_ctrl;
  localparam int NM = 8, NS = 8, DW = 16, TOT = 64;
  localparam logic [7:0]  SYS  = 8'h03;
  localparam logic [63:0] SYNC = 64'hAAAA_AAAA_AAAA_AAAA;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [TOT-1:0] evt = '0;
  logic wr_en = 1'b0, ack = 1'b0, ret = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data, vec;
  logic irq;

  irq_hier_ctrl #(.NUM_MOD(NM), .SRC_N(NS), .DATA_W(DW), .SYS_MODS(SYS), .SYNC_SRCS(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ack_i(ack),
    .ret_i(ret), .irq_o(irq), .irq_vec_o(vec)
  );

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [63:0] m_flag = '0, m_en = '0;
  logic [7:0]  m_moden = '0;
  logic        m_glob = 1'b0, m_insvc = 1'b0;
  logic [15:0] m_vec = '0;
  int          m_settle = 0;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic mod_pending(int m);
    return ((m_flag[m*8 +: 8] & m_en[m*8 +: 8]) != 8'h00) && m_moden[m];
  endfunction

  function automatic logic [15:0] ref_read(logic [4:0] a);
    logic [15:0] r = '0;
    int ai = int'(a);
    if (ai < 8) r[7:0] = m_flag[ai*8 +: 8];
    else if (ai < 16) r[7:0] = m_en[(ai-8)*8 +: 8];
    else if (ai == 16) r[7:0] = m_moden;
    else if (ai == 17) r[0] = m_glob;
    else if (ai == 18) r = m_vec;
    else if (ai == 19) begin
      for (int m = 0; m < NM; m++)
        if (mod_pending(m)) begin
          r[m] = 1'b1;
          if (SYS[m]) r[8] = 1'b1; else r[9] = 1'b1;
        end
    end
    return r;
  endfunction

  function automatic logic ref_irq();
    logic any = 1'b0;
    for (int m = 0; m < NM; m++) any |= mod_pending(m);
    return any && m_glob && !m_insvc && (m_settle == 0);
  endfunction

  task automatic mdl_step();
    logic [63:0] clr = '0;
    if (wr_en && wr_addr < 5'd8) clr[int'(wr_addr)*8 +: 8] = wr_data[7:0];
    m_flag = (m_flag & ~clr) | evt;
    if (wr_en && wr_addr >= 5'd8 && wr_addr < 5'd16) m_en[(int'(wr_addr)-8)*8 +: 8] = wr_data[7:0];
    if (wr_en && wr_addr == 5'd16) m_moden = wr_data[7:0];
    if (wr_en && wr_addr == 5'd17) m_glob = wr_data[0];
    if (wr_en && wr_addr == 5'd18) m_vec = wr_data;
    if (ack) m_insvc = 1'b1; else if (ret) m_insvc = 1'b0;
    if (clr != '0) m_settle = ((clr & SYNC) != '0) ? 2 : 1;
    else if (m_settle > 0) m_settle--;
  endtask

  task automatic cycle();
    @(posedge clk);
    mdl_step();
    @(negedge clk);
    chk("R4", "irq vs model", irq, ref_irq());
    chk("R5", "vector vs model", vec, m_vec);
    chk("R9", "read vs model", rd_data, ref_read(rd_addr));
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_chk(string tag, logic [4:0] a, logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(tag, "register", rd_data, exp);
  endtask

  task automatic pulse(logic [63:0] v);
    evt = v;
    cycle();
    evt = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "vector after reset", vec, 0);
    for (int a = 0; a < 20; a++) rd_chk("R1", 5'(a), 16'h0000);

    // open module 2 sources 0..2, module gate, global gate
    wr(5'd10, 16'h0007);
    wr(5'd16, 16'h0004);
    wr(5'd17, 16'h0001);
    chk("R4", "no flags yet", irq, 0);
    chk("R5", "unprogrammed vector", vec, 0);

    pulse(64'h1 << 16);
    rd_chk("R2", 5'd2, 16'h0001);
    chk("R4", "all gates open", irq, 1);
    rd_chk("R6", 5'd19, 16'h0204);

    // R8: ack masks until ret
    ack = 1'b1; cycle(); ack = 1'b0;
    chk("R8", "masked after ack", irq, 0);
    repeat (3) cycle();
    chk("R8", "still masked", irq, 0);
    ack = 1'b1; ret = 1'b1; cycle(); ack = 1'b0; ret = 1'b0;
    chk("R8", "ack with ret keeps mask", irq, 0);
    ret = 1'b1; cycle(); ret = 1'b0;
    chk("R8", "released by ret", irq, 1);

    // R7 asynchronous window
    pulse(64'h1 << 18);
    wr(5'd2, 16'h0001);
    chk("R7", "async window cycle 1", irq, 0);
    cycle();
    chk("R7", "after async window", irq, 1);
    // R7 synchronous window
    pulse(64'h1 << 17);
    wr(5'd2, 16'h0002);
    chk("R7", "sync window cycle 1", irq, 0);
    cycle();
    chk("R7", "sync window cycle 2", irq, 0);
    cycle();
    chk("R7", "after sync window", irq, 1);
    rd_chk("R2", 5'd2, 16'h0004);

    // R3: set and clear together
    evt = 64'h1 << 16;
    wr(5'd2, 16'h0001);
    evt = '0;
    rd_chk("R3", 5'd2, 16'h0005);

    // R4 gate levels
    cycle(); cycle();
    wr(5'd17, 16'h0000);
    chk("R4", "global gate closed", irq, 0);
    rd_chk("R6", 5'd19, 16'h0204);
    wr(5'd17, 16'h0001);
    chk("R4", "global gate reopened", irq, 1);
    wr(5'd16, 16'h0000);
    chk("R4", "module gate closed", irq, 0);
    wr(5'd16, 16'h0004);
    wr(5'd10, 16'h0000);
    chk("R4", "source gate closed", irq, 0);
    wr(5'd10, 16'h0007);

    // R6 system class
    wr(5'd8, 16'h0008);
    wr(5'd16, 16'h0005);
    pulse(64'h1 << 3);
    rd_chk("R6", 5'd19, 16'h0305);

    // R9 ignored writes
    wr(5'd19, 16'hFFFF);
    rd_chk("R9", 5'd19, 16'h0305);
    wr(5'd25, 16'hFFFF);
    rd_chk("R9", 5'd25, 16'h0000);
    rd_chk("R9", 5'd20, 16'h0000);
    rd_chk("R9", 5'd8, 16'h0008);

    // R5 programmed vector
    wr(5'd18, 16'hBEEF);
    chk("R5", "programmed vector", vec, 16'hBEEF);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      evt = {$urandom & $urandom & $urandom & $urandom, $urandom & $urandom & $urandom & $urandom};
      wr_en = ($urandom % 4) == 0;
      wr_addr = 5'($urandom % 24);
      wr_data = 16'($urandom);
      rd_addr = 5'($urandom % 22);
      ack = ($urandom % 10) == 0;
      ret = ($urandom % 6) == 0;
      cycle();
    end
    evt = '0; wr_en = 1'b0; ack = 1'b0; ret = 1'b0;
    cycle();

    summary();
    $finish;
  end
endmodule